// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block tracks 256 interrupt vectors for one processor. It holds three bit arrays: pending requests, vectors in service, and the trigger mode latched for each vector. Each array is eight 32-bit words. A source posts a request as a vector number and a trigger mode. The block keeps a task priority value and derives a processor priority from it and from the highest vector now in service. When the best pending vector's 16-vector class lies strictly above that priority, the block offers the vector to the processor.

The processor accepts an offered vector with a one-cycle acknowledge pulse, which moves the vector from pending to in service. A one-cycle end-of-interrupt pulse retires the highest vector in service. Each retirement emits a broadcast that carries the retired vector and tells whether it was level- or edge-triggered, so that level sources can re-arm. A directed-EOI enable input suppresses this broadcast.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After synchronous reset, `irq_avail`, `ppr`, `irq_vec` and the broadcast outputs are zero, and the arrays and the task priority are empty.
- R2: When the block is enabled, a request for vector 16 or higher sets its pending bit. `req_accepted` is 1 in that cycle if the bit was clear and 0 if the request merged with one already pending.
- R3: A request for vectors 0 to 15 is refused (`req_accepted` = 0) and never becomes pending or offered.
- R4: While `hw_en` or `sw_en` is low, requests are dropped, and `irq_avail` is 0 from the next clock edge.
- R5: `irq_vec` is the numerically highest pending vector, found by scanning the words from the top and taking the most significant set bit of the first non-zero word.
- R6: `ppr` equals the task priority when its bits [7:4] are at least bits [7:4] of the highest in-service vector (0 when none is in service). Otherwise `ppr` is that vector with its low four bits cleared.
- R7: `irq_avail` is 1 only when a vector is pending and the highest pending vector with its low nibble cleared is strictly greater than `ppr`.
- R8: An `ack` while `irq_avail` is 1 clears the pending bit of `irq_vec`, sets its in-service bit, and the priority follows.
- R9: An `eoi` with a non-empty in-service set clears the highest in-service bit and that vector's trigger bit. It then raises `eoi_out_valid` for one cycle, with `eoi_out_vec` set to that vector and `eoi_out_level` set to the old trigger bit (1 = level).
- R10: No broadcast is emitted when `dir_eoi_en` is 1 or when `eoi` arrives with nothing in service. An `eoi` with nothing in service changes nothing.
- R11: Every enabled request for vector 16 or higher writes the vector's trigger bit from `req_level` (1 = level, 0 = edge), even when the request merges.
- R12: `ppr`, `irq_avail` and `irq_vec` are registered from the array and task priority state one clock after that state changes. The broadcast outputs are registered one clock after the `eoi` edge.
- R13: When an acknowledge and a request for the same vector are taken at the same edge, the request wins and the vector stays pending while it enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| dir_eoi_en | input | 1 | Suppresses the end-of-interrupt broadcast |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | Trigger mode of the request, 1 = level |
| req_accepted | output | 1 | Request newly entered the pending set (combinational) |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| ack | input | 1 | Acknowledge pulse for the offered vector |
| eoi | input | 1 | End-of-interrupt pulse |
| irq_avail | output | 1 | A vector is offered |
| irq_vec | output | 8 | Offered vector, 0 when none is offered |
| ppr | output | 8 | Processor priority |
| eoi_out_valid | output | 1 | End-of-interrupt broadcast strobe |
| eoi_out_vec | output | 8 | Retired vector |
| eoi_out_level | output | 1 | Retired vector was level-triggered |

## Verification
The assertions assume that `ack` and `eoi` are one-cycle pulses sampled on the clock, and that requests, enables and task priority writes are held stable from just after one rising edge to the next. An acknowledge is taken only while `irq_avail` is 1, so the properties need no rule about when the processor may acknowledge. The stimulus drives every input shortly after a rising edge. It raises `ack` only while `irq_avail` is 1 and never in two cycles back to back. It toggles the enables and the directed-EOI input only between whole cycles, so a request, acknowledge and retirement can land in the same cycle without breaking these assumptions.

// File: rtl/intr_prio_pkg.sv
// Shared constants and types for the vectored interrupt priority controller.
// Assumes a vector space that is a power of two split into equal words.
package intr_prio_pkg;
    localparam int unsigned NVEC_DEF   = 256;
    localparam int unsigned WORD_DEF   = 32;
    localparam int unsigned RSV_DEF    = 16;
    localparam int unsigned CLS_W      = 4;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/intr_vec_array.sv
// One vector bit array stored as NVEC/WORD_W words.
// Per edge it first applies a clear (clr_en/clr_idx) and then a write
// (wr_en/wr_idx/wr_val), so a write to the same bit wins over the clear.
// Assumes NVEC is a multiple of WORD_W and both are powers of two.
module intr_vec_array #(
    parameter int unsigned NVEC   = 256,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W  = $clog2(NVEC),
    localparam int unsigned BIT_W  = $clog2(WORD_W),
    localparam int unsigned NWORD  = NVEC / WORD_W,
    localparam int unsigned WSEL_W = IDX_W - BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    output logic [NVEC-1:0]  bits_o
);
    for (genvar w = 0; w < NWORD; w++) begin : g_word
        localparam int unsigned WI = w;
        logic [WORD_W-1:0] word_q;
        logic [WORD_W-1:0] word_d;
        logic              clr_hit;
        logic              wr_hit;

        // Decode whether this word is addressed by the clear or the write.
        always_comb begin
            clr_hit = clr_en && (clr_idx[IDX_W-1:BIT_W] == WSEL_W'(WI));
            wr_hit  = wr_en  && (wr_idx[IDX_W-1:BIT_W]  == WSEL_W'(WI));
        end

        // Build the next word: clear first, then write.
        always_comb begin
            word_d = word_q;
            if (clr_hit) word_d[clr_idx[BIT_W-1:0]] = 1'b0;
            if (wr_hit)  word_d[wr_idx[BIT_W-1:0]]  = wr_val;
        end

        // Hold the word, emptied by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign bits_o[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/intr_find_top.sv
// Finds the highest set bit of a vector array by scanning words from the top
// word down and taking the most significant set bit of the first non-zero word.
// Purely combinational; hit is 0 and idx is 0 when every word is zero.
module intr_find_top #(
    parameter int unsigned NVEC   = 256,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W  = $clog2(NVEC),
    localparam int unsigned BIT_W  = $clog2(WORD_W),
    localparam int unsigned NWORD  = NVEC / WORD_W,
    localparam int unsigned WSEL_W = IDX_W - BIT_W
) (
    input  logic [NVEC-1:0]  bits_i,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [NWORD-1:0] nz;
    logic [BIT_W-1:0] msb [NWORD];

    for (genvar w = 0; w < NWORD; w++) begin : g_enc
        logic [WORD_W-1:0] word;
        assign word  = bits_i[w*WORD_W +: WORD_W];
        assign nz[w] = |word;

        // Priority-encode this word; the highest set bit wins.
        always_comb begin
            msb[w] = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (word[b]) msb[w] = BIT_W'(b);
            end
        end
    end

    // Pick the top non-zero word and join its number with its bit index.
    always_comb begin
        logic [WSEL_W-1:0] sel;
        sel = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (nz[w]) sel = WSEL_W'(w);
        end
        hit = |nz;
        idx = hit ? {sel, msb[sel]} : '0;
    end
endmodule

// File: rtl/intr_prio_eval.sv
// Derives the processor priority from the task priority and the highest
// in-service vector, and decides whether the top pending vector is offered.
// Purely combinational; priorities compare by 16-vector class.
module intr_prio_eval #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned CLS_W = 4,
    localparam int unsigned LOW_W = VEC_W - CLS_W
) (
    input  logic             enabled,
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_hit,
    input  logic [VEC_W-1:0] isr_vec,
    input  logic             irr_hit,
    input  logic [VEC_W-1:0] irr_vec,
    output logic [VEC_W-1:0] ppr,
    output logic             offer
);
    logic [VEC_W-1:0] isr_eff;
    logic [VEC_W-1:0] irr_cls;

    // Choose between task priority and the in-service class.
    always_comb begin
        isr_eff = isr_hit ? isr_vec : '0;
        if (tpr[VEC_W-1:LOW_W] >= isr_eff[VEC_W-1:LOW_W]) ppr = tpr;
        else ppr = {isr_eff[VEC_W-1:LOW_W], {LOW_W{1'b0}}};
    end

    // Offer only a pending class strictly above the processor priority.
    always_comb begin
        irr_cls = {irr_vec[VEC_W-1:LOW_W], {LOW_W{1'b0}}};
        offer   = enabled && irr_hit && (irr_cls > ppr);
    end
endmodule

// File: rtl/intr_prio_ctrl.sv
// Vectored interrupt priority controller top level.
// Keeps pending, in-service and trigger-mode arrays, a task priority and the
// registered offer/priority outputs, and emits the end-of-interrupt broadcast.
// Assumes ack and eoi are one-cycle pulses; ack acts only while irq_avail is 1.
module intr_prio_ctrl #(
    parameter int unsigned NVEC   = intr_prio_pkg::NVEC_DEF,
    parameter int unsigned WORD_W = intr_prio_pkg::WORD_DEF,
    parameter int unsigned RSV    = intr_prio_pkg::RSV_DEF,
    localparam int unsigned VEC_W = $clog2(NVEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             sw_en,
    input  logic             dir_eoi_en,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             req_level,
    output logic             req_accepted,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             ack,
    input  logic             eoi,
    output logic             irq_avail,
    output logic [VEC_W-1:0] irq_vec,
    output logic [VEC_W-1:0] ppr,
    output logic             eoi_out_valid,
    output logic [VEC_W-1:0] eoi_out_vec,
    output logic             eoi_out_level
);
    import intr_prio_pkg::*;

    logic [NVEC-1:0]  irr_bits;
    logic [NVEC-1:0]  isr_bits;
    logic [NVEC-1:0]  tmr_bits;
    logic             irr_hit;
    logic [VEC_W-1:0] irr_top;
    logic             isr_hit;
    logic [VEC_W-1:0] isr_top;
    logic [VEC_W-1:0] tpr_q;
    logic [VEC_W-1:0] ppr_d;
    logic             offer_d;
    logic             enabled;
    logic             req_ok;
    logic             ack_take;
    logic             eoi_take;
    logic             bcast_d;
    trig_e            req_trig;
    trig_e            ret_trig;

    // Qualify the incoming strobes.
    always_comb begin
        enabled      = hw_en && sw_en;
        req_ok       = req_valid && enabled && (req_vec >= VEC_W'(RSV));
        req_accepted = req_ok && !irr_bits[req_vec];
        ack_take     = ack && irq_avail;
        eoi_take     = eoi && isr_hit;
        bcast_d      = eoi_take && !dir_eoi_en;
        req_trig     = req_level ? TRIG_LEVEL : TRIG_EDGE;
        ret_trig     = tmr_bits[isr_top] ? TRIG_LEVEL : TRIG_EDGE;
    end

    // Pending array: acknowledge clears, request sets (request wins).
    intr_vec_array #(.NVEC(NVEC), .WORD_W(WORD_W)) u_irr (
        .clk(clk), .rst_n(rst_n),
        .clr_en(ack_take), .clr_idx(irq_vec),
        .wr_en(req_ok), .wr_idx(req_vec), .wr_val(1'b1),
        .bits_o(irr_bits)
    );

    // In-service array: retirement clears, acknowledge sets.
    intr_vec_array #(.NVEC(NVEC), .WORD_W(WORD_W)) u_isr (
        .clk(clk), .rst_n(rst_n),
        .clr_en(eoi_take), .clr_idx(isr_top),
        .wr_en(ack_take), .wr_idx(irq_vec), .wr_val(1'b1),
        .bits_o(isr_bits)
    );

    // Trigger-mode array: retirement clears, request writes its mode.
    intr_vec_array #(.NVEC(NVEC), .WORD_W(WORD_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr_en(eoi_take), .clr_idx(isr_top),
        .wr_en(req_ok), .wr_idx(req_vec), .wr_val(req_trig == TRIG_LEVEL),
        .bits_o(tmr_bits)
    );

    // Highest pending vector.
    intr_find_top #(.NVEC(NVEC), .WORD_W(WORD_W)) u_top_irr (
        .bits_i(irr_bits), .hit(irr_hit), .idx(irr_top)
    );

    // Highest in-service vector.
    intr_find_top #(.NVEC(NVEC), .WORD_W(WORD_W)) u_top_isr (
        .bits_i(isr_bits), .hit(isr_hit), .idx(isr_top)
    );

    // Priority and offer decision.
    intr_prio_eval #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_eval (
        .enabled(enabled), .tpr(tpr_q),
        .isr_hit(isr_hit), .isr_vec(isr_top),
        .irr_hit(irr_hit), .irr_vec(irr_top),
        .ppr(ppr_d), .offer(offer_d)
    );

    // Task priority register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr_q <= '0;
        else if (tpr_we) tpr_q <= tpr_wdata;
    end

    // Register the priority and the offered vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppr       <= '0;
            irq_avail <= 1'b0;
            irq_vec   <= '0;
        end else begin
            ppr       <= ppr_d;
            irq_avail <= offer_d;
            irq_vec   <= offer_d ? irr_top : '0;
        end
    end

    // Register the end-of-interrupt broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_out_valid <= 1'b0;
            eoi_out_vec   <= '0;
            eoi_out_level <= 1'b0;
        end else begin
            eoi_out_valid <= bcast_d;
            eoi_out_vec   <= bcast_d ? isr_top : '0;
            eoi_out_level <= bcast_d && (ret_trig == TRIG_LEVEL);
        end
    end
endmodule

// File: rtl/intr_prio_ctrl_chk.sv
// Property checker for intr_prio_ctrl, attached by bind.
// Assumes synchronous active-low reset and single-cycle ack/eoi pulses.
module intr_prio_ctrl_chk #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned RSV   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_en,
    input logic             sw_en,
    input logic             dir_eoi_en,
    input logic             req_valid,
    input logic [VEC_W-1:0] req_vec,
    input logic             req_accepted,
    input logic             eoi,
    input logic             irq_avail,
    input logic [VEC_W-1:0] irq_vec,
    input logic [VEC_W-1:0] ppr,
    input logic             eoi_out_valid
);
    // R3: low vectors are never accepted.
    p_low_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_accepted |-> (req_valid && (req_vec >= VEC_W'(RSV))));

    // R3: an offered vector is never a reserved one.
    p_offer_not_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_avail |-> (irq_vec >= VEC_W'(RSV)));

    // R4: nothing is accepted while disabled.
    p_accept_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_accepted |-> (hw_en && sw_en));

    // R4: no offer in the cycle after a disabled cycle.
    p_off_no_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en && sw_en) |=> !irq_avail);

    // R7: an offered class lies strictly above the processor priority.
    p_offer_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_avail |-> ({irq_vec[VEC_W-1:VEC_W-4], 4'h0} > ppr));

    // R9: a broadcast only follows an end-of-interrupt pulse.
    p_bcast_follows_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_out_valid |-> $past(eoi));

    // R10: directed mode keeps the broadcast silent.
    p_directed_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && dir_eoi_en) |=> !eoi_out_valid);
endmodule

bind intr_prio_ctrl intr_prio_ctrl_chk #(.VEC_W(VEC_W), .RSV(RSV)) u_chk (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
    .dir_eoi_en(dir_eoi_en), .req_valid(req_valid), .req_vec(req_vec),
    .req_accepted(req_accepted), .eoi(eoi), .irq_avail(irq_avail),
    .irq_vec(irq_vec), .ppr(ppr), .eoi_out_valid(eoi_out_valid)
);

// File: tb/sim_intr_prio_ctrl.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module sim_intr_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b0, sw_en = 1'b0, dir_eoi_en = 1'b0;
    logic       req_valid = 1'b0, req_level = 1'b0;
    logic [7:0] req_vec = '0;
    logic       tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       ack = 1'b0, eoi = 1'b0;
    logic       req_accepted, irq_avail, eoi_out_valid, eoi_out_level;
    logic [7:0] irq_vec, ppr, eoi_out_vec;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R12";

    always #5 clk = ~clk;

    intr_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .dir_eoi_en(dir_eoi_en), .req_valid(req_valid), .req_vec(req_vec),
        .req_level(req_level), .req_accepted(req_accepted),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ack(ack), .eoi(eoi),
        .irq_avail(irq_avail), .irq_vec(irq_vec), .ppr(ppr),
        .eoi_out_valid(eoi_out_valid), .eoi_out_vec(eoi_out_vec),
        .eoi_out_level(eoi_out_level)
    );

    // Reference model state and expected registered outputs.
    bit [255:0] m_irr, m_isr, m_tmr;
    bit [7:0]   m_tpr;
    bit         e_avail, e_ev, e_elev;
    bit [7:0]   e_vec, e_ppr, e_evec;

    function automatic int top_of(input bit [255:0] a);
        for (int i = 255; i >= 0; i--) if (a[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin : model
        int       hi_isr, hi_irr;
        bit [7:0] isrv, p;
        bit       offer, ack_ok, eoi_ok;
        bit [7:0] old_vec;
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0;
            e_avail = 0; e_vec = 0; e_ppr = 0; e_ev = 0; e_evec = 0; e_elev = 0;
        end else begin
            hi_isr = top_of(m_isr);
            hi_irr = top_of(m_irr);
            isrv   = (hi_isr < 0) ? 8'h00 : 8'(hi_isr);
            p      = (m_tpr[7:4] >= isrv[7:4]) ? m_tpr : {isrv[7:4], 4'h0};
            offer  = hw_en && sw_en && (hi_irr >= 0) && ((8'(hi_irr) & 8'hF0) > p);
            ack_ok = ack && e_avail;
            old_vec = e_vec;
            eoi_ok = eoi && (hi_isr >= 0);
            e_ev   = eoi_ok && !dir_eoi_en;
            e_evec = e_ev ? 8'(hi_isr) : 8'h00;
            e_elev = e_ev ? m_tmr[hi_isr] : 1'b0;
            e_ppr  = p;
            e_avail = offer;
            e_vec  = offer ? 8'(hi_irr) : 8'h00;
            if (eoi_ok) begin m_isr[hi_isr] = 0; m_tmr[hi_isr] = 0; end
            if (ack_ok) begin m_irr[old_vec] = 0; m_isr[old_vec] = 1; end
            if (req_valid && hw_en && sw_en && req_vec >= 8'd16) begin
                m_irr[req_vec] = 1; m_tmr[req_vec] = req_level;
            end
            if (tpr_we) m_tpr = tpr_wdata;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        bit e_acc;
        e_acc = req_valid && hw_en && sw_en && (req_vec >= 8'd16) && !m_irr[req_vec];
        checks++;
        if (irq_avail !== e_avail || irq_vec !== e_vec || ppr !== e_ppr ||
            eoi_out_valid !== e_ev || eoi_out_vec !== e_evec ||
            eoi_out_level !== e_elev || req_accepted !== e_acc) begin
            errors++;
            $display("FAIL %s: avail=%0b vec=%0h ppr=%0h eoi=%0b/%0h/%0b acc=%0b expected avail=%0b vec=%0h ppr=%0h eoi=%0b/%0h/%0b acc=%0b",
                cur_tag, irq_avail, irq_vec, ppr, eoi_out_valid, eoi_out_vec,
                eoi_out_level, req_accepted, e_avail, e_vec, e_ppr, e_ev,
                e_evec, e_elev, e_acc);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        req_valid = 0; ack = 0; eoi = 0; tpr_we = 0;
    endtask

    task automatic post(input int v, input bit lvl);
        req_valid = 1; req_vec = 8'(v); req_level = lvl;
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        bit prev_ack;
        repeat (3) step();
        rst_n = 1; step();
        cur_tag = "R1";
        chk("R1 irq_avail", irq_avail, 0); chk("R1 ppr", ppr, 0);
        chk("R1 eoi_out_valid", eoi_out_valid, 0);
        hw_en = 1; sw_en = 1; step();

        cur_tag = "R2";
        post(8'h45, 0); #1 chk("R2 accepted new", req_accepted, 1);
        step(); chk("R12 not yet offered", irq_avail, 0);
        step(); chk("R12 offered", irq_avail, 1); chk("R5 vec", irq_vec, 8'h45);
        post(8'h45, 1); #1 chk("R2 merged not accepted", req_accepted, 0); step();
        cur_tag = "R3";
        post(8'h0A, 0); #1 chk("R3 low refused", req_accepted, 0); step(); step();
        chk("R3 still 45", irq_vec, 8'h45);
        cur_tag = "R5";
        post(8'h80, 0); step(); post(8'h7F, 0); step(); step();
        chk("R5 highest", irq_vec, 8'h80);

        cur_tag = "R7";
        tpr_we = 1; tpr_wdata = 8'h90; step(); step();
        chk("R6 ppr tpr", ppr, 8'h90); chk("R7 below tpr", irq_avail, 0);
        tpr_we = 1; tpr_wdata = 8'h80; step(); step();
        chk("R7 equal class", irq_avail, 0);
        tpr_we = 1; tpr_wdata = 8'h7F; step(); step();
        chk("R7 above", irq_avail, 1);
        tpr_we = 1; tpr_wdata = 8'h20; step(); step();

        cur_tag = "R8";
        ack = 1; step(); step();
        chk("R8 ppr from isr R6", ppr, 8'h80); chk("R8 nothing above", irq_avail, 0);
        cur_tag = "R9";
        eoi = 1; step();
        chk("R9 bcast", eoi_out_valid, 1); chk("R9 vec", eoi_out_vec, 8'h80);
        chk("R9 edge", eoi_out_level, 0);
        step(); chk("R9 next offered", irq_vec, 8'h7F); chk("R9 ppr back", ppr, 8'h20);
        ack = 1; step(); step(); chk("R8 ppr 70", ppr, 8'h70);
        cur_tag = "R10";
        dir_eoi_en = 1; eoi = 1; step(); chk("R10 directed silent", eoi_out_valid, 0);
        dir_eoi_en = 0; step(); chk("R10 retired anyway", irq_vec, 8'h45);
        cur_tag = "R11";
        ack = 1; step(); step();
        eoi = 1; step();
        chk("R11 level bcast", eoi_out_level, 1); chk("R9 vec 45", eoi_out_vec, 8'h45);
        step(); cur_tag = "R10";
        eoi = 1; step(); chk("R10 empty eoi silent", eoi_out_valid, 0); step();

        cur_tag = "R13";
        post(8'h50, 0); step(); step(); chk("R13 offered", irq_vec, 8'h50);
        ack = 1; post(8'h50, 0); #1 chk("R13 merged", req_accepted, 0);
        step(); step(); chk("R13 ppr 50", ppr, 8'h50); chk("R13 blocked", irq_avail, 0);
        eoi = 1; step(); step();
        chk("R13 still pending", irq_avail, 1); chk("R13 vec", irq_vec, 8'h50);
        ack = 1; step(); step(); eoi = 1; step(); step();

        cur_tag = "R4";
        sw_en = 0; post(8'h60, 0); #1 chk("R4 sw drop", req_accepted, 0);
        step(); step(); chk("R4 off", irq_avail, 0);
        sw_en = 1; step(); step(); chk("R4 dropped", irq_avail, 0);
        post(8'h60, 1); step(); step(); chk("R4 back on", irq_vec, 8'h60);
        hw_en = 0; step(); step(); chk("R4 hw off", irq_avail, 0);
        hw_en = 1; step(); step(); chk("R4 hw on", irq_vec, 8'h60);

        cur_tag = "R12";
        prev_ack = 0;
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(0, 1) == 1) post($urandom_range(0, 255), 1'($urandom_range(0, 1)));
            if (irq_avail && !prev_ack && $urandom_range(0, 2) == 0) ack = 1;
            prev_ack = ack;
            if ($urandom_range(0, 5) == 0) eoi = 1;
            if ($urandom_range(0, 19) == 0) begin tpr_we = 1; tpr_wdata = 8'($urandom_range(0, 255)); end
            if ($urandom_range(0, 15) == 0) dir_eoi_en = ~dir_eoi_en;
            if ($urandom_range(0, 39) == 0) sw_en = ~sw_en;
            if ($urandom_range(0, 59) == 0) hw_en = ~hw_en;
            step();
        end
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule